// File: doc/BRIEF.md
# Synchronous Burst FIFO Data Port

This block is the slave side of a host bus that moves packet data between a host and two internal word buffers. One buffer holds received words and the other collects words for transmission. The host holds an active-low data-select line low to open a burst. While the select stays low, the port moves one word on every rising bus clock and steps its own buffer pointer, so the host never presents a word address. The level of a direction line chooses between a burst into the transmit buffer and a burst out of the receive buffer. An active-low ready-return input lets the host stretch the burst with wait clocks. For burst reads, an active-low cycle strobe must stay high. A read attempted with that strobe low is refused.

All burst control inputs (select, direction, cycle strobe and ready-return) are captured on the falling edge of the bus clock. The rising edge that follows acts on those captured values. A separate register path uses an address qualifier and active-low read and write strobes. It gives access to a scratch configuration word and to a status word. The status word holds two sticky error flags and the fill levels of both buffers. A network-side push port fills the receive buffer, and a head/take port drains the transmit buffer.

FSM states:
- `S_IDLE`: no burst is open.
- `S_RD_XFER`: a word was launched on this edge.
- `S_RD_WAIT`: a read wait clock.
- `S_RD_REJ`: a read refused because of the cycle strobe.
- `S_WR_XFER`: a word was captured on this edge.
- `S_WR_WAIT`: a write wait clock.

FSM transitions:
- Open: from `S_IDLE` with the select sampled low.
- Transfer: select held and no wait sampled.
- Wait: select held and a wait sampled.
- Refuse: a read open with the cycle strobe sampled low.
- Close: any state other than idle, with the select sampled high, returns to `S_IDLE`.

Top module: `burst_port`

## Requirements
- R1: After reset, `doe` is 0, `dout` is 0, `tx_avail` is 0, and the status word reads 0.
- R2: Suppose a falling edge samples `dsel_n`=0, `wr_nrd`=0, `cyc_n`=1 and `rdy_n`=1 while the port is idle. The next rising edge puts the oldest receive-buffer word on `dout`, and `doe` is 1 from then until the burst closes.
- R3: While the select stays sampled low with no wait, every rising edge launches the next receive word in arrival order. The word stays on `dout` until the next launch.
- R4: Each falling edge that samples `rdy_n`=0 during a burst turns the following rising edge into a wait clock. On a wait clock no word is taken or launched, and `dout` holds its value. Consecutive samples give consecutive wait clocks. The same rule applies to write bursts.
- R5: A falling edge that samples `dsel_n`=1 closes the burst on the next rising edge, and `doe` returns to 0. The pointer keeps its place, so a later burst continues with the next unread word.
- R6: If `cyc_n`=0 is sampled when a read burst would open, the port does not start. It takes no word and holds `doe` at 0 until the select is released.
- R7: With `wr_nrd`=1 sampled at the open, each non-wait rising edge captures `din` into the transmit buffer in order, and `doe` stays 0 for the whole burst.
- R8: A read launch from an empty receive buffer leaves `dout` at the last launched word (0 if there was none). It also sets status bit 0, which stays set until cleared.
- R9: A write into a full transmit buffer drops the word and leaves the buffer contents unchanged. It also sets status bit 1, which stays set until cleared.
- R10: A rising edge with `as_n`=0 latches `addr`. A rising edge that sees `wr_n` return high after a low cycle commits the `din` value captured during the low cycle. `rd_n`=0 with `dsel_n`=1 while idle drives the addressed register on `dout` at once, with `doe`=1. The register map is:
  - Address 0: scratch word, readable and writable.
  - Address 1: status word. Bit 0 is underflow, bit 1 is overflow, bits 15:8 hold the receive count and bits 23:16 hold the transmit count. Writing 1 to bit 0 or bit 1 clears that flag.
  - Other addresses read 0.
- R11: `rx_push` stores `rx_push_data` unless the receive buffer is full, in which case the word is lost. `tx_avail` is 1 while the transmit buffer holds a word, `tx_head` shows the oldest word, and `tx_take` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsel_n | input | 1 | Active-low burst data select |
| cyc_n | input | 1 | Active-low cycle strobe, must be high for reads |
| wr_nrd | input | 1 | Burst direction, 1 = write to transmit buffer |
| rdy_n | input | 1 | Active-low ready-return, requests a wait clock |
| as_n | input | 1 | Active-low address qualifier for registers |
| rd_n | input | 1 | Active-low register read strobe |
| wr_n | input | 1 | Active-low register write strobe |
| addr | input | ADDR_W | Register address |
| din | input | DATA_W | Write data from host |
| dout | output | DATA_W | Read data to host |
| doe | output | 1 | Data bus drive enable |
| rx_push | input | 1 | Network-side receive word strobe |
| rx_push_data | input | DATA_W | Network-side receive word |
| tx_avail | output | 1 | Transmit buffer not empty |
| tx_head | output | DATA_W | Oldest transmit word |
| tx_take | input | 1 | Remove oldest transmit word |

## Verification
The bench sweeps every 4-bit wait pattern over read bursts and every 3-bit pattern over write bursts, and keeps queue models in step with the design. It then checks the words in order:
- A design that advanced the pointer on a wait clock would skip a word.
- A design that reloaded the pointer at each new select would repeat a word.

It drives the receive buffer past empty and the transmit buffer past full. A wrong design would show garbage on `dout`, overwrite held words, or lose the sticky bit. It opens a read with the cycle strobe low, which exposes a design that pops a word it never delivers. It also checks that flags clear only on a written 1.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
package bp_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_XFER,
        S_RD_WAIT,
        S_RD_REJ,
        S_WR_XFER,
        S_WR_WAIT
    } bp_state_e;

    localparam int unsigned REG_SCRATCH = 0;
    localparam int unsigned REG_STATUS  = 1;
    localparam int unsigned STAT_RX_LSB = 8;
    localparam int unsigned STAT_TX_LSB = 16;

endpackage

// File: rtl/bp_fifo.sv
`timescale 1ns/1ps
module bp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic          do_push, do_pop, full;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp_q];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp_q] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            count <= '0;
        end else begin
            if (do_push) wp_q <= bump(wp_q);
            if (do_pop)  rp_q <= bump(rp_q);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/bp_sample.sv
`timescale 1ns/1ps
module bp_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic dsel_n,
    input  logic cyc_n,
    input  logic wr_nrd,
    input  logic rdy_n,
    output logic sel_s,
    output logic cyc_s,
    output logic dir_s,
    output logic wait_s
);

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_s  <= 1'b0;
            cyc_s  <= 1'b0;
            dir_s  <= 1'b0;
            wait_s <= 1'b0;
        end else begin
            sel_s  <= !dsel_n;
            cyc_s  <= !cyc_n;
            dir_s  <= wr_nrd;
            wait_s <= !rdy_n;
        end
    end

endmodule

// File: rtl/bp_regs.sv
`timescale 1ns/1ps
module bp_regs
    import bp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2,
    parameter int CW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              unf,
    input  logic              ovf,
    input  logic [CW-1:0]     rx_cnt,
    input  logic [CW-1:0]     tx_cnt,
    output logic [DATA_W-1:0] rdata,
    output logic              clr_unf,
    output logic              clr_ovf
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q, scratch_q, status;
    logic              wr_n_q, commit, hit_scr, hit_stat;

    assign commit   = !wr_n_q && wr_n;
    assign hit_scr  = (addr_q == ADDR_W'(REG_SCRATCH));
    assign hit_stat = (addr_q == ADDR_W'(REG_STATUS));
    assign clr_unf  = commit && hit_stat && din_q[0];
    assign clr_ovf  = commit && hit_stat && din_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            din_q     <= '0;
            wr_n_q    <= 1'b1;
            scratch_q <= '0;
        end else begin
            wr_n_q <= wr_n;
            if (!as_n) addr_q <= addr;
            if (!wr_n) din_q  <= din;
            if (commit && hit_scr) scratch_q <= din_q;
        end
    end

    always_comb begin
        status = '0;
        status[0] = unf;
        status[1] = ovf;
        status[STAT_RX_LSB +: CW] = rx_cnt;
        status[STAT_TX_LSB +: CW] = tx_cnt;
    end

    always_comb begin
        rdata = '0;
        if (hit_scr)       rdata = scratch_q;
        else if (hit_stat) rdata = status;
    end

endmodule

// File: rtl/burst_port.sv
`timescale 1ns/1ps
module burst_port
    import bp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2,
    parameter int DEPTH  = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              dsel_n,
    input  logic              cyc_n,
    input  logic              wr_nrd,
    input  logic              rdy_n,
    input  logic              as_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              doe,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_push_data,
    output logic              tx_avail,
    output logic [DATA_W-1:0] tx_head,
    input  logic              tx_take
);

    bp_state_e         st_q, st_nx;
    logic              sel_s, cyc_s, dir_s, wait_s;
    logic              rx_pop, rx_empty, tx_push, tx_empty, tx_full;
    logic              rd_go, wr_go, unf_evt, ovf_evt;
    logic              unf_q, ovf_q, clr_unf, clr_ovf, reg_rd;
    logic [CW-1:0]     rx_cnt, tx_cnt;
    logic [DATA_W-1:0] rx_head, rd_word_q, reg_rdata;

    bp_sample u_sample (
        .clk    (bclk),
        .rst_n  (rst_n),
        .dsel_n (dsel_n),
        .cyc_n  (cyc_n),
        .wr_nrd (wr_nrd),
        .rdy_n  (rdy_n),
        .sel_s  (sel_s),
        .cyc_s  (cyc_s),
        .dir_s  (dir_s),
        .wait_s (wait_s)
    );

    bp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx (
        .clk       (bclk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .empty     (rx_empty),
        .count     (rx_cnt)
    );

    bp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx (
        .clk       (bclk),
        .rst_n     (rst_n),
        .push      (tx_push),
        .push_data (din),
        .pop       (tx_take),
        .head      (tx_head),
        .empty     (tx_empty),
        .count     (tx_cnt)
    );

    bp_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CW(CW)) u_regs (
        .clk     (bclk),
        .rst_n   (rst_n),
        .as_n    (as_n),
        .wr_n    (wr_n),
        .addr    (addr),
        .din     (din),
        .unf     (unf_q),
        .ovf     (ovf_q),
        .rx_cnt  (rx_cnt),
        .tx_cnt  (tx_cnt),
        .rdata   (reg_rdata),
        .clr_unf (clr_unf),
        .clr_ovf (clr_ovf)
    );

    // Next state from the falling-edge samples
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (sel_s) begin
                    if (dir_s)      st_nx = wait_s ? S_WR_WAIT : S_WR_XFER;
                    else if (cyc_s) st_nx = S_RD_REJ;
                    else            st_nx = wait_s ? S_RD_WAIT : S_RD_XFER;
                end
            end
            S_RD_XFER, S_RD_WAIT: begin
                if (!sel_s) st_nx = S_IDLE;
                else        st_nx = wait_s ? S_RD_WAIT : S_RD_XFER;
            end
            S_RD_REJ: begin
                if (!sel_s) st_nx = S_IDLE;
            end
            S_WR_XFER, S_WR_WAIT: begin
                if (!sel_s) st_nx = S_IDLE;
                else        st_nx = wait_s ? S_WR_WAIT : S_WR_XFER;
            end
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_nx;
    end

    // Per-edge actions and bus outputs
    always_comb begin
        rd_go    = (st_nx == S_RD_XFER);
        wr_go    = (st_nx == S_WR_XFER);
        tx_full  = (tx_cnt == CW'(DEPTH));
        rx_pop   = rd_go && !rx_empty;
        unf_evt  = rd_go && rx_empty;
        tx_push  = wr_go && !tx_full;
        ovf_evt  = wr_go && tx_full;
        reg_rd   = !rd_n && dsel_n && (st_q == S_IDLE);
        doe      = reg_rd || (st_q == S_RD_XFER) || (st_q == S_RD_WAIT);
        dout     = reg_rd ? reg_rdata : rd_word_q;
        tx_avail = !tx_empty;
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            rd_word_q <= '0;
            unf_q     <= 1'b0;
            ovf_q     <= 1'b0;
        end else begin
            if (rx_pop) rd_word_q <= rx_head;
            if (unf_evt)      unf_q <= 1'b1;
            else if (clr_unf) unf_q <= 1'b0;
            if (ovf_evt)      ovf_q <= 1'b1;
            else if (clr_ovf) ovf_q <= 1'b0;
        end
    end

endmodule

// File: rtl/bp_checker.sv
`timescale 1ns/1ps
module bp_checker
    import bp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int CW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input bp_state_e         st_q,
    input logic              sel_s,
    input logic              dir_s,
    input logic              cyc_s,
    input logic              wait_s,
    input logic              rx_pop,
    input logic [DATA_W-1:0] rd_word_q,
    input logic              doe,
    input logic              unf_q,
    input logic              ovf_q,
    input logic              clr_unf,
    input logic              clr_ovf,
    input logic [CW-1:0]     tx_cnt
);

    p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_pop) |-> (st_q == S_RD_XFER && doe));

    p_wait_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_RD_XFER && sel_s && wait_s) |=> (st_q == S_RD_WAIT));

    p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_RD_WAIT) |-> ($stable(rd_word_q) && !$past(rx_pop)));

    p_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_s && st_q != S_IDLE) |=> (st_q == S_IDLE));

    p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && sel_s && !dir_s && cyc_s) |=> (st_q == S_RD_REJ && !doe));

    p_wr_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && sel_s && dir_s && !wait_s) |=> (st_q == S_WR_XFER));

    p_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_WR_XFER || st_q == S_WR_WAIT) |-> !doe);

    p_unf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unf_q) |-> $past(clr_unf));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_q) |-> $past(clr_ovf));

    p_tx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CW'(DEPTH));

endmodule

bind burst_port bp_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk       (bclk),
    .rst_n     (rst_n),
    .st_q      (st_q),
    .sel_s     (sel_s),
    .dir_s     (dir_s),
    .cyc_s     (cyc_s),
    .wait_s    (wait_s),
    .rx_pop    (rx_pop),
    .rd_word_q (rd_word_q),
    .doe       (doe),
    .unf_q     (unf_q),
    .ovf_q     (ovf_q),
    .clr_unf   (clr_unf),
    .clr_ovf   (clr_ovf),
    .tx_cnt    (tx_cnt)
);

// File: tb/burst_port_tb_top.sv
`timescale 1ns/1ps
module burst_port_tb_top;

    localparam int DW    = 32;
    localparam int AW    = 2;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dsel_n = 1'b1, cyc_n = 1'b1, wr_nrd = 1'b0, rdy_n = 1'b1;
    logic          as_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0, dout, tx_head, rx_push_data = '0;
    logic          doe, tx_avail, rx_push = 1'b0, tx_take = 1'b0;

    int tests = 0;
    int fails = 0;

    logic [DW-1:0] rxq[$];
    logic [DW-1:0] txq[$];
    logic [DW-1:0] last_word = '0;
    logic          unf_exp = 1'b0, ovf_exp = 1'b0;
    int            rx_seq = 0;

    always #2 clk = ~clk;

    burst_port #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(DEPTH)) dut_i (
        .bclk(clk), .rst_n(rst_n), .dsel_n(dsel_n), .cyc_n(cyc_n),
        .wr_nrd(wr_nrd), .rdy_n(rdy_n), .as_n(as_n), .rd_n(rd_n),
        .wr_n(wr_n), .addr(addr), .din(din), .dout(dout), .doe(doe),
        .rx_push(rx_push), .rx_push_data(rx_push_data),
        .tx_avail(tx_avail), .tx_head(tx_head), .tx_take(tx_take)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] stat_exp();
        return {8'h00, 8'(txq.size()), 8'(rxq.size()), 6'h00, ovf_exp, unf_exp};
    endfunction

    task automatic reg_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        as_n = 1'b0; addr = a;
        step();
        as_n = 1'b1; wr_n = 1'b0; din = d;
        step();
        wr_n = 1'b1;
        step();
    endtask

    task automatic reg_read(input logic [AW-1:0] a, output logic [DW-1:0] v);
        as_n = 1'b0; addr = a;
        step();
        as_n = 1'b1; rd_n = 1'b0;
        #1;
        v = dout;
        chk("R10 read drive", 32'(doe), 32'd1);
        rd_n = 1'b1;
        step();
    endtask

    task automatic check_status(input string req);
        logic [DW-1:0] v;
        reg_read(AW'(1), v);
        chk(req, v, stat_exp());
    endtask

    task automatic net_push(input logic [DW-1:0] v);
        rx_push = 1'b1; rx_push_data = v;
        step();
        rx_push = 1'b0;
        if (rxq.size() < DEPTH) rxq.push_back(v);
    endtask

    task automatic rd_burst(input int n, input logic [15:0] wmask);
        for (int i = 0; i < n; i++) begin
            dsel_n = 1'b0; wr_nrd = 1'b0; cyc_n = 1'b1; rdy_n = !wmask[i];
            step();
            chk("R2 doe in read", 32'(doe), 32'd1);
            if (wmask[i]) begin
                chk("R4 hold on wait", dout, last_word);
            end else if (rxq.size() > 0) begin
                last_word = rxq.pop_front();
                chk((i == 0) ? "R2 first word" : "R3 next word", dout, last_word);
            end else begin
                unf_exp = 1'b1;
                chk("R8 empty read keeps word", dout, last_word);
            end
        end
        dsel_n = 1'b1; rdy_n = 1'b1;
        step();
        chk("R5 close", 32'(doe), 32'd0);
    endtask

    task automatic wr_burst(input int n, input logic [15:0] wmask, input logic [DW-1:0] base);
        for (int i = 0; i < n; i++) begin
            dsel_n = 1'b0; wr_nrd = 1'b1; rdy_n = !wmask[i]; din = base + DW'(i);
            step();
            chk("R7 no drive", 32'(doe), 32'd0);
            if (!wmask[i]) begin
                if (txq.size() < DEPTH) txq.push_back(base + DW'(i));
                else ovf_exp = 1'b1;
            end
        end
        dsel_n = 1'b1; wr_nrd = 1'b0; rdy_n = 1'b1;
        step();
    endtask

    task automatic drain_tx(input string req);
        for (int g = 0; g < DEPTH + 2 && tx_avail; g++) begin
            if (txq.size() > 0) chk(req, tx_head, txq.pop_front());
            else chk(req, 32'd1, 32'd0);
            tx_take = 1'b1;
            step();
            tx_take = 1'b0;
        end
        chk(req, 32'(txq.size()), 32'd0);
        chk("R11 tx empty", 32'(tx_avail), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 doe", 32'(doe), 32'd0);
        chk("R1 dout", dout, 32'd0);
        chk("R1 tx_avail", 32'(tx_avail), 32'd0);
        check_status("R1 status");

        // R10 scratch sweep and unmapped addresses
        for (int i = 0; i < 8; i++) begin
            reg_write(AW'(0), 32'h1357_9BDF ^ (32'h0101_0101 * DW'(i)));
            reg_read(AW'(0), v);
            chk("R10 scratch", v, 32'h1357_9BDF ^ (32'h0101_0101 * DW'(i)));
        end
        reg_read(AW'(2), v); chk("R10 unmapped", v, 32'd0);
        reg_read(AW'(3), v); chk("R10 unmapped", v, 32'd0);

        // R11 fill receive buffer past capacity
        for (int k = 0; k < DEPTH + 2; k++) begin
            net_push(32'hC0DE_0000 + DW'(rx_seq));
            rx_seq++;
        end
        check_status("R11 rx count");

        // R2 R3 R4 R5 sweep all 4-bit wait patterns
        for (int pat = 0; pat < 16; pat++) begin
            for (int k = 0; k < 2; k++) begin
                net_push(32'hC0DE_0000 + DW'(rx_seq));
                rx_seq++;
            end
            rd_burst(4, 16'(pat));
        end
        check_status("R5 rx count after bursts");

        // R6 refused read
        net_push(32'hC0DE_0000 + DW'(rx_seq));
        rx_seq++;
        for (int i = 0; i < 3; i++) begin
            dsel_n = 1'b0; wr_nrd = 1'b0; cyc_n = 1'b0;
            step();
            chk("R6 no drive", 32'(doe), 32'd0);
        end
        dsel_n = 1'b1; cyc_n = 1'b1;
        step();
        check_status("R6 count unchanged");

        // R8 drain past empty
        rd_burst(rxq.size() + 2, 16'h0);
        check_status("R8 underflow flag");
        reg_write(AW'(1), 32'h0000_0002);
        check_status("R8 underflow kept when bit0 not written");
        reg_write(AW'(1), 32'h0000_0001);
        unf_exp = 1'b0;
        check_status("R10 underflow clear");

        // R7 R4 write sweep
        for (int pat = 0; pat < 8; pat++) begin
            wr_burst(3, 16'(pat), 32'hA000_0000 + (DW'(pat) << 8));
            drain_tx("R7 tx order");
        end

        // R9 overflow
        wr_burst(DEPTH + 2, 16'h0, 32'hB000_0000);
        check_status("R9 overflow flag");
        drain_tx("R9 kept words");
        reg_write(AW'(1), 32'h0000_0002);
        ovf_exp = 1'b0;
        check_status("R10 overflow clear");

        // R5 resume after release
        net_push(32'h5EED_0001);
        net_push(32'h5EED_0002);
        rd_burst(1, 16'h0);
        rd_burst(2, 16'h1);
        rd_burst(1, 16'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule